// File: doc/BRIEF.md
# Data Address Translation and Access Check Stage

This block is a single-cycle pipeline stage that sits after the data TLB lookup in a load/store path. It takes the virtual address of a load or store with its size, its request flags and the processor's privilege state, plus whatever the TLB returned for that address. One cycle later it presents either a physical address with an uncacheable marker, or a fault code with a set of memory-management status flags. A trap unit can use these flags to report the fault.

The checks run in a fixed priority order. Alignment is checked first. Then comes one of three paths: a physical bypass, a direct-mapped kernel superpage window, or a TLB path. The TLB path checks for a miss, then for read or write permission in the effective mode, then for the fault-on-read and fault-on-write bits. Any address that gets through is checked against the implemented physical width and then decoded for the uncacheable region. The effective privilege mode takes PAL-mode execution into account: when the PC's low bit is set, kernel mode applies, or the alternate mode when the request asks for it. The TLB storage and the dispatch of faults are outside this block.

Top module: `dtrans_check`

## Requirements
- R1: While `rst` is high, `rsp_valid` is 0 and all other outputs are 0. Each cycle with `req_valid` high gives a response with `rsp_valid` high on the next clock edge. The response outputs hold their values while `req_valid` is low.
- R2: The alignment check comes before every other check. If `req_va & (2**req_size_lg2 - 1)` is nonzero, the fault code is 1 (misaligned). The status is only the write flag (bit 0), which is set for stores.
- R3: Permission checks use an effective mode. When `pc_lsb` is 0, the effective mode is `cur_mode`. When `pc_lsb` is 1, it is `alt_mode` if `req_alt` is set and kernel (0) otherwise. Mode codes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: When `req_phys` is set, there is no translation. The candidate PA is the full VA, the VA canonical check is skipped, and the TLB inputs are ignored.
- R5: A non-physical VA whose bits 63:43 are not all equal to bit 42 gives fault code 3 (page-type fault). The status is bad-VA (bit 2) plus access violation (bit 1), plus write (bit 0) for a store.
- R6: A canonical non-physical VA with bits 47:41 equal to 7'h7e is in the superpage window. If `cur_mode` is not kernel, it gives fault code 2 (access violation) with status acv plus write for a store. The PAL override does not apply to this check.
- R7: A kernel superpage PA is VA bits 43:0 with bits 43:40 forced to 4'hF when VA bit 40 is 1 and cleared to 0 when it is 0.
- R8: A TLB-path access with `tlb_hit` low gives fault code 5 if `req_vpte` is set and 4 otherwise. The status is miss (bit 5) plus write for a store.
- R9: On a TLB hit that passes the permission checks, the PA is `{tlb_ppn, req_va[12:0]}` (8 KB pages).
- R10: For a store hit, `tlb_wr_en[mode]` is checked first. If it is clear, the result is fault code 3 with status write, acv, and fault-on-write (bit 4) when `tlb_fonw` is set. If it passes and `tlb_fonw` is set, the result is fault code 3 with status write plus fault-on-write.
- R11: For a load hit, `tlb_rd_en[mode]` is checked first. If it is clear, the result is fault code 2 with status acv, plus fault-on-read (bit 3) when `tlb_fonr` is set. If it passes and `tlb_fonr` is set, the result is fault code 3 with status fault-on-read only.
- R12: A candidate PA with any bit above bit 43 set gives fault code 6 (machine check) with status 0.
- R13: If candidate PA bit 43 is set: when bits 43:20 are all ones, the result is fault code 7 (unimplemented space) with status 0. Otherwise `rsp_uncached` is 1 and PA bits 42:35 are returned as 0.
- R14: Whenever the fault code is nonzero, `rsp_pa` and `rsp_uncached` are 0. When the fault code is 0, the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_va | input | 64 | Virtual address |
| req_size_lg2 | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use the alternate mode under PAL execution |
| req_vpte | input | 1 | Request is a virtual page-table fetch |
| pc_lsb | input | 1 | PC bit 0 (PAL-mode execution) |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables, indexed by mode |
| tlb_wr_en | input | 4 | Per-mode write enables, indexed by mode |
| tlb_fonr | input | 1 | Entry's fault-on-read bit |
| tlb_fonw | input | 1 | Entry's fault-on-write bit |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault code (0 none) |
| rsp_stat | output | 6 | Status flags: 5 miss, 4 fonw, 3 fonr, 2 bad VA, 1 acv, 0 write |

## Verification
Random stimulus draws addresses from five classes:
- arbitrary 64-bit values, which mostly fail the canonical check;
- sign-extended canonical addresses;
- superpage-window addresses, sometimes with bits 39:20 all ones;
- small physical addresses;
- physical addresses with junk upper bits.

The random stimulus also mixes sizes, mode states, hit and miss, enable masks and fault-on bits. The address class and the mix show whether the path selection and its priority are right: a check earlier in the order has to hide every later one. Directed cases cover the boundaries. These include a superpage access that the PAL override does not rescue, the two encodings of the superpage bit-40 rule, an IPR-space address against an ordinary uncacheable address, and each step of the store and load permission order.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int VA_W       = 64;
    localparam int PA_W       = 44;
    localparam int PAGE_SHIFT = 13;
    localparam int MODE_W     = 2;
    localparam int NUM_MODES  = 1 << MODE_W;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_PAGE     = 3'd3,
        FLT_MISS     = 3'd4,
        FLT_PTE_MISS = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMP    = 3'd7
    } fault_e;

    typedef enum logic [1:0] {
        PM_KERNEL = 2'd0,
        PM_EXEC   = 2'd1,
        PM_SUPER  = 2'd2,
        PM_USER   = 2'd3
    } pmode_e;

    // Packed MSB first: miss is bit 5, wr is bit 0
    typedef struct packed {
        logic miss;
        logic fonw;
        logic fonr;
        logic bad_va;
        logic acv;
        logic wr;
    } mmstat_t;

    typedef struct packed {
        fault_e  fault;
        mmstat_t stat;
    } verdict_t;

    function automatic mmstat_t stat_clear();
        mmstat_t s;
        s = '0;
        return s;
    endfunction

    function automatic logic misaligned(input logic [2:0] lo, input logic [1:0] size_lg2);
        logic [3:0] m;
        m = (4'd1 << size_lg2) - 4'd1;
        return |(lo & m[2:0]);
    endfunction

endpackage

// File: rtl/dtc_mode_sel.sv
module dtc_mode_sel
    import dtc_pkg::*;
(
    input  logic   pc_lsb,
    input  logic   use_alt,
    input  pmode_e cur_mode,
    input  pmode_e alt_mode,
    output pmode_e eff_mode
);

    always_comb begin
        if (pc_lsb) begin
            eff_mode = use_alt ? alt_mode : PM_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end

endmodule

// File: rtl/dtc_va_map.sv
module dtc_va_map #(
    parameter int VA_W     = 64,
    parameter int PA_W     = 44,
    parameter int SIGN_BIT = 42,
    parameter int SP_HI    = 47,
    parameter int SP_LO    = 41,
    parameter int SP_TAG   = 7'h7e,
    parameter int EXT_BIT  = 40
) (
    input  logic [VA_W-1:0] va,
    output logic            va_canon,
    output logic            in_super,
    output logic [PA_W-1:0] super_pa
);

    localparam int EXT_N = VA_W - SIGN_BIT;   // bits SIGN_BIT..VA_W-1
    localparam int SP_N  = SP_HI - SP_LO + 1;
    localparam int TOP_N = PA_W - EXT_BIT;    // bits forced by the extension rule

    logic [EXT_N-1:0] upper;
    logic [PA_W-1:0]  base;

    assign upper    = va[VA_W-1:SIGN_BIT];
    assign va_canon = (upper == '0) || (upper == '1);
    assign in_super = (va[SP_HI:SP_LO] == SP_N'(SP_TAG));
    assign base     = va[PA_W-1:0];

    always_comb begin
        super_pa = base;
        if (base[EXT_BIT]) begin
            super_pa[PA_W-1:EXT_BIT] = '1;
        end else begin
            super_pa[PA_W-1:EXT_BIT] = '0;
        end
    end

    // R7: the forced top field is uniform and tracks the extension bit
    always_comb begin
        if (in_super) begin
            sp_ext_chk: assert (super_pa[PA_W-1:EXT_BIT] == {TOP_N{base[EXT_BIT]}});
        end
    end

endmodule

// File: rtl/dtc_perm.sv
module dtc_perm
    import dtc_pkg::*;
#(
    parameter int NMODES = 4
) (
    input  logic              is_write,
    input  pmode_e            mode,
    input  logic [NMODES-1:0] rd_en,
    input  logic [NMODES-1:0] wr_en,
    input  logic              fonr,
    input  logic              fonw,
    output verdict_t          verdict
);

    logic allowed;

    // one enable per mode, picked from the mask of the access's direction
    generate
        if (NMODES == 1) begin : g_single
            assign allowed = is_write ? wr_en[0] : rd_en[0];
        end else begin : g_multi
            assign allowed = is_write ? wr_en[mode] : rd_en[mode];
        end
    endgenerate

    always_comb begin
        verdict.fault = FLT_NONE;
        verdict.stat  = stat_clear();
        if (is_write) begin
            if (!allowed) begin
                verdict.fault     = FLT_PAGE;
                verdict.stat.wr   = 1'b1;
                verdict.stat.acv  = 1'b1;
                verdict.stat.fonw = fonw;
            end else if (fonw) begin
                verdict.fault     = FLT_PAGE;
                verdict.stat.wr   = 1'b1;
                verdict.stat.fonw = 1'b1;
            end
        end else begin
            if (!allowed) begin
                verdict.fault     = FLT_ACV;
                verdict.stat.acv  = 1'b1;
                verdict.stat.fonr = fonr;
            end else if (fonr) begin
                verdict.fault     = FLT_PAGE;
                verdict.stat.fonr = 1'b1;
            end
        end
    end

    // R10 R11: a load never flags fault-on-write, a store never flags fault-on-read
    always_comb begin
        dir_flag_chk: assert (!(is_write && verdict.stat.fonr) && !(!is_write && verdict.stat.fonw));
    end

endmodule

// File: rtl/dtc_pa_qual.sv
module dtc_pa_qual
    import dtc_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 44,
    parameter int CLR_HI = 42,
    parameter int CLR_LO = 35,
    parameter int IPR_LO = 20
) (
    input  logic [VA_W-1:0] cand,
    output fault_e          fault,
    output logic [PA_W-1:0] pa,
    output logic            uncached
);

    localparam int UC_BIT = PA_W - 1;

    logic [PA_W-1:0] clr_mask;

    generate
        for (genvar b = 0; b < PA_W; b++) begin : g_mask
            assign clr_mask[b] = (b >= CLR_LO) && (b <= CLR_HI);
        end
    endgenerate

    logic            out_of_range;
    logic            ipr_space;
    logic [PA_W-1:0] low;

    assign low          = cand[PA_W-1:0];
    assign out_of_range = |cand[VA_W-1:PA_W];
    assign ipr_space    = &low[PA_W-1:IPR_LO];

    always_comb begin
        fault    = FLT_NONE;
        pa       = '0;
        uncached = 1'b0;
        if (out_of_range) begin
            fault = FLT_MCHK;
        end else if (low[UC_BIT]) begin
            if (ipr_space) begin
                fault = FLT_UNIMP;
            end else begin
                uncached = 1'b1;
                pa       = low & ~clr_mask;
            end
        end else begin
            pa = low;
        end
    end

endmodule

// File: rtl/dtrans_check.sv
module dtrans_check
    import dtc_pkg::*;
#(
    parameter int P_VA_W       = dtc_pkg::VA_W,
    parameter int P_PA_W       = dtc_pkg::PA_W,
    parameter int P_PAGE_SHIFT = dtc_pkg::PAGE_SHIFT,
    parameter int P_NMODES     = dtc_pkg::NUM_MODES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic [63:0]                      req_va,
    input  logic [1:0]                       req_size_lg2,
    input  logic                             req_write,
    input  logic                             req_phys,
    input  logic                             req_alt,
    input  logic                             req_vpte,
    input  logic                             pc_lsb,
    input  logic [1:0]                       cur_mode,
    input  logic [1:0]                       alt_mode,
    input  logic                             tlb_hit,
    input  logic [30:0]                      tlb_ppn,
    input  logic [3:0]                       tlb_rd_en,
    input  logic [3:0]                       tlb_wr_en,
    input  logic                             tlb_fonr,
    input  logic                             tlb_fonw,
    output logic                             rsp_valid,
    output logic [43:0]                      rsp_pa,
    output logic                             rsp_uncached,
    output logic [2:0]                       rsp_fault,
    output logic [5:0]                       rsp_stat
);

    localparam int PPN_W  = P_PA_W - P_PAGE_SHIFT;
    localparam int CLR_HI = P_PA_W - 2;
    localparam int CLR_LO = P_PA_W - 9;

    pmode_e   eff_mode;
    logic     va_canon;
    logic     in_super;
    logic [P_PA_W-1:0] super_pa;
    logic [P_PA_W-1:0] hit_pa;
    verdict_t perm_v;
    fault_e   qual_fault;
    logic [P_PA_W-1:0] qual_pa;
    logic     qual_unc;
    logic [P_VA_W-1:0] cand;
    logic     use_qual;
    logic     bad_align;

    fault_e            nxt_fault;
    mmstat_t           nxt_stat;
    logic [P_PA_W-1:0] nxt_pa;
    logic              nxt_unc;

    dtc_mode_sel u_mode (
        .pc_lsb   (pc_lsb),
        .use_alt  (req_alt),
        .cur_mode (pmode_e'(cur_mode)),
        .alt_mode (pmode_e'(alt_mode)),
        .eff_mode (eff_mode)
    );

    dtc_va_map #(
        .VA_W (P_VA_W),
        .PA_W (P_PA_W)
    ) u_vamap (
        .va       (req_va),
        .va_canon (va_canon),
        .in_super (in_super),
        .super_pa (super_pa)
    );

    dtc_perm #(
        .NMODES (P_NMODES)
    ) u_perm (
        .is_write (req_write),
        .mode     (eff_mode),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fonr     (tlb_fonr),
        .fonw     (tlb_fonw),
        .verdict  (perm_v)
    );

    dtc_pa_qual #(
        .VA_W   (P_VA_W),
        .PA_W   (P_PA_W),
        .CLR_HI (CLR_HI),
        .CLR_LO (CLR_LO)
    ) u_qual (
        .cand     (cand),
        .fault    (qual_fault),
        .pa       (qual_pa),
        .uncached (qual_unc)
    );

    assign hit_pa    = {tlb_ppn[PPN_W-1:0], req_va[P_PAGE_SHIFT-1:0]};
    assign bad_align = misaligned(req_va[2:0], req_size_lg2);

    // fixed priority: alignment, path select, miss, permissions, PA qualification
    always_comb begin
        nxt_fault = FLT_NONE;
        nxt_stat  = stat_clear();
        use_qual  = 1'b0;
        cand      = '0;
        if (bad_align) begin
            nxt_fault   = FLT_ALIGN;
            nxt_stat.wr = req_write;
        end else if (req_phys) begin
            use_qual = 1'b1;
            cand     = req_va;
        end else if (!va_canon) begin
            nxt_fault       = FLT_PAGE;
            nxt_stat.wr     = req_write;
            nxt_stat.acv    = 1'b1;
            nxt_stat.bad_va = 1'b1;
        end else if (in_super) begin
            if (pmode_e'(cur_mode) != PM_KERNEL) begin
                nxt_fault    = FLT_ACV;
                nxt_stat.wr  = req_write;
                nxt_stat.acv = 1'b1;
            end else begin
                use_qual = 1'b1;
                cand     = P_VA_W'(super_pa);
            end
        end else if (!tlb_hit) begin
            nxt_fault     = req_vpte ? FLT_PTE_MISS : FLT_MISS;
            nxt_stat.wr   = req_write;
            nxt_stat.miss = 1'b1;
        end else if (perm_v.fault != FLT_NONE) begin
            nxt_fault = perm_v.fault;
            nxt_stat  = perm_v.stat;
        end else begin
            use_qual = 1'b1;
            cand     = P_VA_W'(hit_pa);
        end

        nxt_pa  = '0;
        nxt_unc = 1'b0;
        if (use_qual) begin
            nxt_fault = qual_fault;
            nxt_pa    = qual_pa;
            nxt_unc   = qual_unc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= '0;
            rsp_stat     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= nxt_pa;
                rsp_uncached <= nxt_unc;
                rsp_fault    <= nxt_fault;
                rsp_stat     <= nxt_stat;
            end
        end
    end

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    align_first_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_align) |=> (rsp_fault == FLT_ALIGN));

    // R14
    pa_zero_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

    // R13
    uc_field_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_uncached) |-> (rsp_pa[CLR_HI:CLR_LO] == '0 && rsp_pa[P_PA_W-1]));

    // R8
    miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_stat[5] == (rsp_fault == FLT_MISS || rsp_fault == FLT_PTE_MISS)));

    // R10 R11
    fon_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_stat[3] && rsp_stat[4]));

endmodule

// File: tb/dtrans_check_bench.sv
module dtrans_check_bench;

    typedef struct packed {
        logic [43:0] pa;
        logic        unc;
        logic [2:0]  flt;
        logic [5:0]  st;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size_lg2 = '0;
    logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_vpte = 1'b0;
    logic        pc_lsb = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        tlb_hit = 1'b0;
    logic [30:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
    logic        rsp_valid;
    logic [43:0] rsp_pa;
    logic        rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_stat;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dtrans_check u_dtrans_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_size_lg2(req_size_lg2), .req_write(req_write), .req_phys(req_phys),
        .req_alt(req_alt), .req_vpte(req_vpte), .pc_lsb(pc_lsb),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
        .rsp_stat(rsp_stat)
    );

    // expected result from the requirements
    function automatic exp_t model(
        input logic [63:0] va, input logic [1:0] sz, input logic wr, input logic ph,
        input logic alt, input logic vpte, input logic pcl, input logic [1:0] cm,
        input logic [1:0] am, input logic hit, input logic [30:0] ppn,
        input logic [3:0] rde, input logic [3:0] wre, input logic fr, input logic fw);
        exp_t e;
        logic [63:0] p;
        logic [63:0] m;
        logic go;
        logic [1:0] em;
        e  = '0;
        p  = '0;
        go = 1'b0;
        m  = (64'd1 << sz) - 64'd1;
        em = pcl ? (alt ? am : 2'd0) : cm;
        if ((va & m) != 0) begin
            e.flt = 3'd1; e.st[0] = wr;
        end else if (ph) begin
            p = va; go = 1'b1;
        end else if (va[63:42] != 22'h0 && va[63:42] != 22'h3fffff) begin
            e.flt = 3'd3; e.st[2] = 1'b1; e.st[1] = 1'b1; e.st[0] = wr;
        end else if (va[47:41] == 7'h7e) begin
            if (cm != 2'd0) begin
                e.flt = 3'd2; e.st[1] = 1'b1; e.st[0] = wr;
            end else begin
                p = {20'h0, va[43:0]};
                p[43:40] = va[40] ? 4'hf : 4'h0;
                go = 1'b1;
            end
        end else if (!hit) begin
            e.flt = vpte ? 3'd5 : 3'd4; e.st[5] = 1'b1; e.st[0] = wr;
        end else if (wr) begin
            if (!wre[em]) begin
                e.flt = 3'd3; e.st[0] = 1'b1; e.st[1] = 1'b1; e.st[4] = fw;
            end else if (fw) begin
                e.flt = 3'd3; e.st[0] = 1'b1; e.st[4] = 1'b1;
            end else begin
                p = {20'h0, ppn, va[12:0]}; go = 1'b1;
            end
        end else begin
            if (!rde[em]) begin
                e.flt = 3'd2; e.st[1] = 1'b1; e.st[3] = fr;
            end else if (fr) begin
                e.flt = 3'd3; e.st[3] = 1'b1;
            end else begin
                p = {20'h0, ppn, va[12:0]}; go = 1'b1;
            end
        end
        if (go) begin
            if (p[63:44] != 0) begin
                e.flt = 3'd6;
            end else if (p[43]) begin
                if (p[43:20] == 24'hffffff) begin
                    e.flt = 3'd7;
                end else begin
                    p[42:35] = 8'h0;
                    e.unc = 1'b1;
                    e.pa = p[43:0];
                end
            end else begin
                e.pa = p[43:0];
            end
        end
        return e;
    endfunction

    function automatic string tag_of(input exp_t e);
        case (e.flt)
            3'd0: return e.unc ? "R13" : "R9";
            3'd1: return "R2";
            3'd2: return "R6";
            3'd3: return "R5";
            3'd4, 3'd5: return "R8";
            3'd6: return "R12";
            default: return "R13";
        endcase
    endfunction

    // called right after a falling edge; checks at the next falling edge
    task automatic do_req(
        input logic [63:0] va, input logic [1:0] sz, input logic wr, input logic ph,
        input logic alt, input logic vpte, input logic pcl, input logic [1:0] cm,
        input logic [1:0] am, input logic hit, input logic [30:0] ppn,
        input logic [3:0] rde, input logic [3:0] wre, input logic fr, input logic fw,
        input string tag);
        exp_t e;
        string t;
        req_va = va; req_size_lg2 = sz; req_write = wr; req_phys = ph; req_alt = alt;
        req_vpte = vpte; pc_lsb = pcl; cur_mode = cm; alt_mode = am; tlb_hit = hit;
        tlb_ppn = ppn; tlb_rd_en = rde; tlb_wr_en = wre; tlb_fonr = fr; tlb_fonw = fw;
        req_valid = 1'b1;
        e = model(va, sz, wr, ph, alt, vpte, pcl, cm, am, hit, ppn, rde, wre, fr, fw);
        t = (tag == "") ? tag_of(e) : tag;
        @(negedge clk);
        req_valid = 1'b0;
        total++;
        if (!rsp_valid || rsp_pa !== e.pa || rsp_uncached !== e.unc ||
            rsp_fault !== e.flt || rsp_stat !== e.st) begin
            fails++;
            $display("FAIL %s (R14 side): va=%h got v=%b pa=%h unc=%b flt=%0d st=%b exp pa=%h unc=%b flt=%0d st=%b",
                     t, va, rsp_valid, rsp_pa, rsp_uncached, rsp_fault, rsp_stat,
                     e.pa, e.unc, e.flt, e.st);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog R1: got timeout exp completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        logic [63:0] va;
        logic [30:0] ppn;
        int cls;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (rsp_valid !== 1'b0 || rsp_pa !== '0 || rsp_fault !== '0 || rsp_stat !== '0 || rsp_uncached !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b pa=%h flt=%0d st=%b exp all zero", rsp_valid, rsp_pa, rsp_fault, rsp_stat);
        end
        rst = 1'b0;
        @(negedge clk);

        // R2: misaligned store beats physical bypass; misaligned load; byte always aligned
        do_req(64'h2, 2'd2, 1, 1, 0, 0, 0, 0, 0, 1, 31'h0, 4'hf, 4'hf, 0, 0, "R2");
        do_req(64'hdead_0000_0000_0004, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 31'h0, 4'hf, 4'hf, 0, 0, "R2");
        do_req(64'h0000_0000_0000_2007, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 31'h55, 4'hf, 4'hf, 0, 0, "R2");
        // R3: PAL override to kernel, to alternate mode, and no override
        do_req(64'h0000_0000_0001_2340, 2'd3, 1, 0, 0, 0, 1, 3, 3, 1, 31'h77, 4'h0, 4'h1, 0, 0, "R3");
        do_req(64'h0000_0000_0001_2340, 2'd3, 0, 0, 1, 0, 1, 0, 3, 1, 31'h77, 4'h7, 4'h0, 0, 0, "R3");
        do_req(64'h0000_0000_0001_2340, 2'd3, 0, 0, 0, 0, 0, 3, 0, 1, 31'h77, 4'h7, 4'h0, 0, 0, "R3");
        // R4: physical bypass ignores a miss
        do_req(64'h0000_0123_4567_89a8, 2'd3, 0, 1, 0, 0, 0, 3, 0, 0, 31'h0, 4'h0, 4'h0, 1, 1, "R4");
        // R5: non-canonical store
        do_req(64'h0000_0800_0000_0000, 2'd3, 1, 0, 0, 0, 0, 0, 0, 1, 31'h1, 4'hf, 4'hf, 0, 0, "R5");
        // R6: superpage from user mode, PAL override does not help
        do_req(64'hffff_fc00_1234_5678, 2'd3, 1, 0, 0, 0, 1, 3, 0, 1, 31'h1, 4'hf, 4'hf, 0, 0, "R6");
        // R7: superpage, bit 40 clear and set
        do_req(64'hffff_fc00_1234_5678, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 31'h0, 4'h0, 4'h0, 0, 0, "R7");
        do_req(64'hffff_fd00_0000_1000, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 31'h0, 4'h0, 4'h0, 0, 0, "R7");
        // R8: miss with and without page-table flag
        do_req(64'h0000_0000_0040_0000, 2'd3, 1, 0, 0, 1, 0, 0, 0, 0, 31'h0, 4'hf, 4'hf, 0, 0, "R8");
        do_req(64'h0000_0000_0040_0000, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 31'h0, 4'hf, 4'hf, 0, 0, "R8");
        // R9: hit
        do_req(64'h0000_0000_0001_2345, 2'd0, 0, 0, 0, 0, 0, 2, 0, 1, 31'h0abc, 4'h4, 4'h0, 0, 0, "R9");
        // R10: store enable fail with fonw, then enable pass with fonw
        do_req(64'h0000_0000_0002_0000, 2'd3, 1, 0, 0, 0, 0, 1, 0, 1, 31'h10, 4'hf, 4'hd, 0, 1, "R10");
        do_req(64'h0000_0000_0002_0000, 2'd3, 1, 0, 0, 0, 0, 1, 0, 1, 31'h10, 4'hf, 4'h2, 1, 1, "R10");
        // R11: load enable fail with fonr, then enable pass with fonr
        do_req(64'h0000_0000_0002_0000, 2'd3, 0, 0, 0, 0, 0, 2, 0, 1, 31'h10, 4'hb, 4'hf, 1, 1, "R11");
        do_req(64'h0000_0000_0002_0000, 2'd3, 0, 0, 0, 0, 0, 2, 0, 1, 31'h10, 4'h4, 4'h0, 1, 1, "R11");
        // R12: physical with bits above the implemented width
        do_req(64'h0001_0000_0000_0000, 2'd3, 0, 1, 0, 0, 0, 0, 0, 0, 31'h0, 4'h0, 4'h0, 0, 0, "R12");
        // R13: IPR space, then plain uncacheable
        do_req(64'h0000_0fff_fff0_0000, 2'd3, 0, 1, 0, 0, 0, 0, 0, 0, 31'h0, 4'h0, 4'h0, 0, 0, "R13");
        do_req(64'h0000_0fff_8000_0040, 2'd3, 0, 1, 0, 0, 0, 0, 0, 0, 31'h0, 4'h0, 4'h0, 0, 0, "R13");
        // R14: fault zeroes PA even when the TLB data would map
        do_req(64'h0000_0000_0003_0000, 2'd3, 0, 0, 0, 0, 0, 3, 0, 1, 31'h7fffffff, 4'h7, 4'hf, 0, 0, "R14");

        // R1: outputs hold while idle
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 3'd2) begin
            fails++;
            $display("FAIL R1 hold: got v=%b flt=%0d exp v=0 flt=2", rsp_valid, rsp_fault);
        end

        for (int i = 0; i < 4000; i++) begin
            r   = {$urandom(), $urandom()};
            cls = int'($urandom() % 5);
            case (cls)
                0: va = r;
                1: va = {{21{r[42]}}, r[42:0]};
                2: begin
                    va = {16'hffff, 7'h7e, r[40:0]};
                    if ($urandom() % 4 == 0) va[39:20] = '1;
                end
                3: va = {20'h0, r[43:0]};
                default: va = {r[63:44] | 20'h1, r[43:0]};
            endcase
            if ($urandom() % 4 != 0) va[2:0] = 3'b000;
            ppn = 31'($urandom());
            if ($urandom() % 4 == 0) ppn[30:7] = '1;
            do_req(va, 2'($urandom()), 1'($urandom()),
                   (cls >= 3) ? 1'b1 : ($urandom() % 8 == 0),
                   1'($urandom()), 1'($urandom()), 1'($urandom()),
                   2'($urandom()), 2'($urandom()), ($urandom() % 4 != 0), ppn,
                   4'($urandom()), 4'($urandom()),
                   ($urandom() % 4 == 0), ($urandom() % 4 == 0), "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule